// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a logical address, made of a segment number and an offset inside that segment, into a physical address. Each segment is described by one entry in a table held in ordinary memory. An entry is two words: the segment's starting physical address, then its length. The table's start and its number of entries sit in two configuration registers, so switching context means rewriting only those two values.

A translation is a fixed sequence. The segment number is first compared with the table size. If it is in range, the entry's two words are fetched through a simple read port, the offset is compared with the segment length, and the base is added to the offset. A failed compare ends the translation with an addressing trap instead of an address. Each translation costs at most two memory reads and two comparisons.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and done_o, trap_o, mem_req_o and paddr_o are 0. Both configuration registers reset to 0, so any translation traps until the table size is written.
- R2: A cycle with cfg_we_i=1 writes cfg_wdata_i to the table start (cfg_sel_i=0) or the table size (cfg_sel_i=1). The new value applies to translations accepted on later cycles. A write made while a translation is in flight does not change that translation.
- R3: A segment number greater than or equal to the table size raises done_o and trap_o=1 in the cycle after acceptance, and no memory read is issued.
- R4: If the offset is greater than or equal to the fetched segment length, done_o comes with trap_o=1, and paddr_o is 0 whenever trap_o is 1 with done_o.
- R5: If the offset is below the fetched segment length, done_o comes with trap_o=0 and paddr_o = base + offset, taken modulo 2^AW.
- R6: Memory is addressed in words. The first read is at table_start + 2*segment and returns the base. The second read is at table_start + 2*segment + 1 and returns the length.
- R7: mem_req_o stays high with mem_addr_o unchanged until a cycle in which mem_rvalid_i is 1. mem_rdata_i is taken in that cycle.
- R8: A request is accepted on a cycle where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the acceptance of an in-range request until its done cycle, and req_valid_i is ignored during that time.
- R9: done_o is high for exactly one cycle, which is the cycle after the edge that samples mem_rvalid_i for the length read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = table start, 1 = table size |
| cfg_wdata_i | input | AW | Configuration write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit is idle and can accept a request |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset within the segment |
| mem_req_o | output | 1 | Table read request, held until served |
| mem_addr_o | output | AW | Table word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | AW | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Addressing trap for the completed translation |
| paddr_o | output | AW | Physical address, 0 on a trap |

## Verification
The assertions take for granted that the memory asserts mem_rvalid_i only while mem_req_o is high, and that it answers each held request exactly once. The bench memory model keeps to this: it waits a random 0 to 2 cycles after seeing a request, pulses read-valid for one cycle with the word at the presented address, and then rests for a cycle. The table always lies inside the modelled memory, with the table start below 101 and the size at most 40 entries, so entry addresses never wrap. Offsets are chosen just below, at, and far from each fetched length, so that both sides of the limit compare are exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_BASE = 2'd1,
    ST_RD_LIM  = 2'd2
  } xl_state_e;

  localparam logic CFG_SEL_BASE = 1'b0;
  localparam logic CFG_SEL_LEN  = 1'b1;
  localparam int unsigned ENT_WORDS = 2;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] tbase_o,
  output logic [AW-1:0] tlen_o
);
  import seg_xlate_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbase_o <= '0;
      tlen_o  <= '0;
    end else if (we_i) begin
      if (sel_i == CFG_SEL_BASE) tbase_o <= wdata_i;
      else                       tlen_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [AW-1:0]    seg_base_i,
  input  logic [AW-1:0]    seg_lim_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             fault_o,
  output logic [AW-1:0]    paddr_o
);
  logic [AW-1:0] off_ext;

  assign off_ext = {{(AW-OFF_W){1'b0}}, off_i};
  assign fault_o = !(off_ext < seg_lim_i);
  assign paddr_o = seg_base_i + off_ext;
endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SEG_W = 8,
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [AW-1:0]    tbase_i,
  input  logic [AW-1:0]    tlen_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic [AW-1:0]    ent_base_o,
  output logic [OFF_W-1:0] ent_off_o,
  input  logic             chk_fault_i,
  input  logic [AW-1:0]    chk_paddr_i,
  output logic             done_o,
  output logic             trap_o,
  output logic [AW-1:0]    paddr_o
);
  import seg_xlate_pkg::*;

  localparam int unsigned ENT_SHIFT = $clog2(ENT_WORDS);

  xl_state_e        state_q;
  logic [AW-1:0]    addr_q, base_q, seg_ext;
  logic [OFF_W-1:0] off_q;
  logic             done_q, trap_q, accept, seg_ok;
  logic [AW-1:0]    paddr_q;

  assign seg_ext     = {{(AW-SEG_W){1'b0}}, req_seg_i};
  assign seg_ok      = seg_ext < tlen_i;
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign ent_base_o  = base_q;
  assign ent_off_o   = off_q;
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign paddr_o     = paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (seg_ok) begin
            state_q <= ST_RD_BASE;
            addr_q  <= tbase_i + (seg_ext << ENT_SHIFT);
            off_q   <= req_off_i;
          end else begin
            done_q  <= 1'b1;
            trap_q  <= 1'b1;
            paddr_q <= '0;
          end
        end
        ST_RD_BASE: if (mem_rvalid_i) begin
          base_q  <= mem_rdata_i;
          addr_q  <= addr_q + 1'b1;
          state_q <= ST_RD_LIM;
        end
        ST_RD_LIM: if (mem_rvalid_i) begin
          done_q  <= 1'b1;
          trap_q  <= chk_fault_i;
          paddr_q <= chk_fault_i ? '0 : chk_paddr_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_seg_trap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !({{(AW-SEG_W){1'b0}}, req_seg_i} < tlen_i))
      |=> (done_o && trap_o && !mem_req_o));

  assert_trap_noaddr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trap_o) |-> (paddr_o == '0));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_done_time_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_LIM && mem_rvalid_i) |=> (done_o && req_ready_o));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SEG_W = 8,
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             trap_o,
  output logic [AW-1:0]    paddr_o
);
  logic [AW-1:0]    tbase, tlen, ent_base, chk_paddr;
  logic [OFF_W-1:0] ent_off;
  logic             chk_fault;

  seg_cfg_regs #(.AW(AW)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .tbase_o (tbase),
    .tlen_o  (tlen)
  );

  // length word is checked straight off the read bus
  seg_bound_chk #(.AW(AW), .OFF_W(OFF_W)) i_chk (
    .seg_base_i (ent_base),
    .seg_lim_i  (mem_rdata_i),
    .off_i      (ent_off),
    .fault_o    (chk_fault),
    .paddr_o    (chk_paddr)
  );

  seg_fetch_fsm #(.AW(AW), .SEG_W(SEG_W), .OFF_W(OFF_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_seg_i    (req_seg_i),
    .req_off_i    (req_off_i),
    .tbase_i      (tbase),
    .tlen_i       (tlen),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .ent_base_o   (ent_base),
    .ent_off_o    (ent_off),
    .chk_fault_i  (chk_fault),
    .chk_paddr_i  (chk_paddr),
    .done_o       (done_o),
    .trap_o       (trap_o),
    .paddr_o      (paddr_o)
  );
endmodule

// File: tb/test_seg_xlate.sv
`timescale 1ns/100ps
module test_seg_xlate;
  localparam int AW = 32, SEG_W = 8, OFF_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr, mem_rdata = '0;
  logic done, trap;
  logic [AW-1:0] paddr;

  int checks = 0, fails = 0, cycles = 0;
  logic [AW-1:0] bmem [256];
  int nrd = 0, lat = 0;
  logic [AW-1:0] rd_addr [2];
  logic [AW-1:0] m_base = '0, m_len = '0;

  always #2 clk_i = ~clk_i;

  seg_xlate #(.AW(AW), .SEG_W(SEG_W), .OFF_W(OFF_W)) i_seg_xlate (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_seg_i(req_seg), .req_off_i(req_off), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .trap_o(trap), .paddr_o(paddr)
  );

  // memory model: random latency, one-cycle valid pulse, one idle cycle after
  always @(negedge clk_i) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      lat = $urandom_range(2, 0);
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = bmem[mem_addr[7:0]];
        if (nrd < 2) rd_addr[nrd] = mem_addr;
        nrd++;
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] val);
    @(negedge clk_i); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk_i); #1;
    cfg_we = 1'b0;
    if (sel) m_len = val; else m_base = val;
  endtask

  task automatic xlate(input logic [SEG_W-1:0] seg, input logic [OFF_W-1:0] off,
                       input bit mid_cfg, input bit hold_valid);
    logic [AW-1:0] ea, eb, el, ep;
    bit in_rng, et, prev_last;
    int cyc;
    in_rng = {24'd0, seg} < m_len;
    ea = m_base + 2 * {24'd0, seg};
    eb = bmem[ea[7:0]];
    el = bmem[8'(ea[7:0] + 8'd1)];
    et = !in_rng || !({16'd0, off} < el);
    ep = et ? '0 : eb + {16'd0, off};
    @(negedge clk_i); #1;
    chk(req_ready == 1'b1, "R8 ready when idle", AW'(req_ready), 1);
    req_valid = 1'b1; req_seg = seg; req_off = off; nrd = 0;
    @(negedge clk_i); #1;
    if (hold_valid) begin req_seg = ~seg; req_off = ~off; end
    else req_valid = 1'b0;
    if (in_rng) chk(req_ready == 1'b0, "R8 busy after accept", AW'(req_ready), 0);
    if (mid_cfg) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = '0; end
    cyc = 0; prev_last = 1'b0;
    while (!done && cyc < 40) begin
      prev_last = mem_rvalid && (nrd == 2);
      @(negedge clk_i); #1;
      cfg_we = 1'b0;
      cyc++;
    end
    req_valid = 1'b0;
    if (mid_cfg) m_len = '0;
    chk(done == 1'b1, "R9 done seen", AW'(done), 1);
    if (!in_rng) begin
      chk(cyc == 0, "R3 trap one cycle after accept", AW'(cyc), 0);
      chk(nrd == 0, "R3 no memory read", AW'(nrd), 0);
      chk(trap == 1'b1, "R3 trap flag", AW'(trap), 1);
    end else begin
      chk(nrd == 2, "R6 two reads", AW'(nrd), 2);
      chk(rd_addr[0] == ea, "R6 base word address", rd_addr[0], ea);
      chk(rd_addr[1] == ea + 1, "R6 length word address", rd_addr[1], ea + 1);
      chk(prev_last == 1'b1, "R9 done after length read", AW'(prev_last), 1);
      chk(trap == et, et ? "R4 offset trap" : "R5 no trap", AW'(trap), AW'(et));
    end
    chk(paddr == ep, et ? "R4 paddr zero on trap" : "R5 base plus offset", paddr, ep);
    @(negedge clk_i); #1;
    chk(done == 1'b0, "R9 done single cycle", AW'(done), 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) bmem[i] = $urandom_range(90000, 0);
    bmem[120] = 32'hFFFF_FFF0; bmem[121] = 32'd100;
    repeat (3) @(negedge clk_i);
    #1;
    chk(req_ready == 1'b1 && done == 1'b0 && trap == 1'b0 && mem_req == 1'b0 && paddr == '0,
        "R1 reset outputs", {req_ready, done, trap, mem_req}, 32'h8);
    rst_ni = 1'b1;
    xlate(8'd0, 16'd0, 1'b0, 1'b0);          // R1 table size 0 traps
    cfg_write(1'b0, 32'd100);
    cfg_write(1'b1, 32'd20);                 // R2
    xlate(8'd10, 16'h0020, 1'b0, 1'b0);      // R5 wraparound at entry 120
    xlate(8'd10, 16'd99, 1'b0, 1'b0);        // R5 just below limit
    xlate(8'd10, 16'd100, 1'b0, 1'b0);       // R4 at limit
    xlate(8'd19, 16'd5, 1'b0, 1'b0);         // last in range
    xlate(8'd20, 16'd5, 1'b0, 1'b0);         // R3 at table size
    xlate(8'd255, 16'd5, 1'b0, 1'b0);        // R3 max segment
    xlate(8'd3, 16'd7, 1'b0, 1'b1);          // R8 valid held while busy
    xlate(8'd4, 16'd1, 1'b1, 1'b0);          // R2 write mid-flight ignored
    xlate(8'd4, 16'd1, 1'b0, 1'b0);          // R2 new size 0 now traps
    for (int n = 0; n < 300; n++) begin
      logic [SEG_W-1:0] s;
      logic [OFF_W-1:0] o;
      logic [AW-1:0] lim;
      int k;
      if (n % 25 == 0) begin
        cfg_write(1'b0, AW'($urandom_range(100, 0)));
        cfg_write(1'b1, AW'($urandom_range(40, 0)));
      end
      s = SEG_W'($urandom_range(47, 0));
      lim = bmem[8'(m_base[7:0] + 2 * s + 1)];
      k = $urandom_range(3, 0);
      if (k == 0 && lim != 0) o = OFF_W'(lim - 1);
      else if (k == 1) o = OFF_W'(lim);
      else o = OFF_W'($urandom);
      xlate(s, o, 1'b0, (k == 3));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule